// File: doc/BRIEF.md
# Edge-Triggered Sticky Interrupt Aggregator

This block gathers the event interrupts of a receiver into one interrupt terminal. It watches two groups of level status inputs, all synchronous to the block clock. Lock indicators raise one flag when they go high and a second, separate flag when they go low. Plain event inputs (failures, thresholds, measurement done, message and FIFO conditions, supply faults) raise a flag only when they go high. Each flag is sticky: it stays set until the host writes a 1 to it.

A simple register port gives the host the flag word, a per-flag enable word and a small control word. The interrupt condition is the OR of all enabled flags, gated by a global enable. It is then shaped into a pad drive value and a pad output-enable. The control word selects the polarity, push-pull or open-drain drive, and whether the shared terminal serves as the interrupt pin at all. The global enable and the pin settings only shape the terminal. The flags the host reads are never affected by them.

Top module: `irq_aggregator`

## Requirements
- R1: A 0-to-1 change of lock input i, seen one clock after the previous sample, sets flag bit i (bits 0 to NLOCK-1).
- R2: A 1-to-0 change of lock input i sets flag bit NLOCK+i, a flag distinct from the one set in R1.
- R3: A 0-to-1 change of event input j sets flag bit 2*NLOCK+j. A 1-to-0 change, or a level held high, sets nothing.
- R4: Flags are read at address 0 and stay set until the host writes address 0 with a 1 in that bit position. Bits written as 0 are left unchanged.
- R5: When an event and a write-1-to-clear hit the same flag on the same clock, the flag ends up set.
- R6: The enable word sits at address 1, with the same bit layout as the flags. The interrupt is asserted only while some flag and its enable bit are both 1. The enable word does not change the flag value that is read.
- R7: Control bit 0 (address 2) is the global enable. While it is 0 the interrupt is never asserted, and the flags still read back unchanged.
- R8: Control bit 1 selects polarity. At 0, the drive value equals the asserted state. At 1, it is the inverse of that state.
- R9: Control bit 2 selects the drive type. At 0 (push-pull) the output-enable is high whenever the pin is selected. At 1 (open-drain) it is high only while the interrupt is asserted.
- R10: While control bit 3 (pin select) is 0, the output-enable stays low.
- R11: After reset, flags, enables and control read 0, the output-enable is low, and address 3 reads 0.
- R12: On the first clock after reset release, no edge is taken, so inputs already high at reset set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_sts | input | NLOCK | Lock status levels (lock and unlock events) |
| evt_sts | input | NRISE | Event status levels (rising events only) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 flags, 1 enables, 2 control |
| reg_wdata | input | 2*NLOCK+NRISE | Write data |
| reg_rdata | output | 2*NLOCK+NRISE | Read data for reg_addr (combinational) |
| irq_drv | output | 1 | Drive value for the interrupt terminal |
| irq_oe | output | 1 | Output-enable for the interrupt terminal |

## Verification
The hardest case to reach from the ports is a new event and a host clear landing on the same flag in the same clock. The bench first lowers a lock input and lets a clock pass. At one falling clock edge it then raises that input again and presents a clear write covering both the lock flag and the unlock flag. A correct design keeps the lock flag set and clears the unlock flag. The bench also holds every input high through reset to show that the first clock after release takes no edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int CTRL_W = 4;

  typedef struct packed {
    logic pin_sel;     // bit 3
    logic open_drain;  // bit 2
    logic act_low;     // bit 1
    logic gen_en;      // bit 0
  } irq_ctrl_t;

  typedef enum logic [1:0] {
    ADDR_FLAG = 2'd0,
    ADDR_EN   = 2'd1,
    ADDR_CTRL = 2'd2,
    ADDR_NONE = 2'd3
  } irq_addr_e;

  function automatic logic pin_level(input logic asserted, input logic act_low);
    return asserted ^ act_low;
  endfunction

  function automatic logic pin_enable(input logic asserted, input irq_ctrl_t c);
    if (!c.pin_sel) return 1'b0;
    if (c.open_drain) return asserted;
    return 1'b1;
  endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int NLOCK = 5,
  parameter int NRISE = 13,
  localparam int NFLAG = 2 * NLOCK + NRISE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLOCK-1:0] lock_in,
  input  logic [NRISE-1:0] evt_in,
  output logic             armed,
  output logic [NFLAG-1:0] set_req
);

  logic [NLOCK-1:0] lock_q;
  logic [NRISE-1:0] evt_q;

  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic fall_of(input logic cur, input logic prev);
    return ~cur & prev;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '0;
      evt_q  <= '0;
      armed  <= 1'b0;
    end else begin
      lock_q <= lock_in;
      evt_q  <= evt_in;
      armed  <= 1'b1;
    end
  end

  for (genvar i = 0; i < NLOCK; i++) begin : g_lock
    assign set_req[i]         = armed & rise_of(lock_in[i], lock_q[i]);
    assign set_req[NLOCK + i] = armed & fall_of(lock_in[i], lock_q[i]);
  end

  for (genvar j = 0; j < NRISE; j++) begin : g_evt
    assign set_req[2 * NLOCK + j] = armed & rise_of(evt_in[j], evt_q[j]);
  end

  AST_NO_EDGE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(set_req) == '0); // R12

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NFLAG = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_req,
  input  logic [NFLAG-1:0] clr_req,
  output logic [NFLAG-1:0] flags
);

  function automatic logic [NFLAG-1:0] next_flags(input logic [NFLAG-1:0] cur,
                                                   input logic [NFLAG-1:0] set,
                                                   input logic [NFLAG-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= next_flags(flags, set_req, clr_req);
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags) & ~$past(clr_req)) & ~flags) == '0)); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req != '0) |=> ((flags & $past(set_req)) == $past(set_req))); // R5

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flags & ~$past(flags)) & ~$past(set_req)) == '0)); // R4

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_agg_pkg::*;
#(
  parameter int NFLAG = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [NFLAG-1:0] wdata,
  input  logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] en,
  output irq_ctrl_t        ctrl,
  output logic [NFLAG-1:0] clr_req,
  output logic [NFLAG-1:0] rdata
);

  localparam int PAD_W = NFLAG - CTRL_W;

  irq_addr_e sel;
  assign sel = irq_addr_e'(addr);

  assign clr_req = (wr && sel == ADDR_FLAG) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      ctrl <= '0;
    end else if (wr) begin
      if (sel == ADDR_EN)   en   <= wdata;
      if (sel == ADDR_CTRL) ctrl <= irq_ctrl_t'(wdata[CTRL_W-1:0]);
    end
  end

  always_comb begin
    case (sel)
      ADDR_FLAG: rdata = flags;
      ADDR_EN:   rdata = en;
      ADDR_CTRL: rdata = {{PAD_W{1'b0}}, ctrl};
      default:   rdata = '0;
    endcase
  end

  AST_EN_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(en) && $stable(ctrl)); // R6

endmodule

// File: rtl/irq_pin_shaper.sv
module irq_pin_shaper
  import irq_agg_pkg::*;
#(
  parameter int NFLAG = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] en,
  input  irq_ctrl_t        ctrl,
  output logic             asserted,
  output logic             drv,
  output logic             oe
);

  logic any_enabled;
  assign any_enabled = |(flags & en);
  assign asserted    = ctrl.gen_en & any_enabled;
  assign drv         = pin_level(asserted, ctrl.act_low);
  assign oe          = pin_enable(asserted, ctrl);

  AST_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.pin_sel |-> !oe); // R10

  AST_OD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.open_drain && !any_enabled) |-> !oe); // R9

  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.gen_en |-> (drv == ctrl.act_low)); // R7

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & en) == '0) |-> (drv == ctrl.act_low)); // R6

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NLOCK = 5,
  parameter int NRISE = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NLOCK-1:0]           lock_sts,
  input  logic [NRISE-1:0]           evt_sts,
  input  logic                       reg_wr,
  input  logic [1:0]                 reg_addr,
  input  logic [2*NLOCK+NRISE-1:0]   reg_wdata,
  output logic [2*NLOCK+NRISE-1:0]   reg_rdata,
  output logic                       irq_drv,
  output logic                       irq_oe
);

  localparam int NFLAG = 2 * NLOCK + NRISE;

  logic             armed;
  logic             asserted;
  logic [NFLAG-1:0] set_req;
  logic [NFLAG-1:0] clr_req;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] en;
  irq_ctrl_t        ctrl;

  irq_edge_detect #(.NLOCK(NLOCK), .NRISE(NRISE)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_in (lock_sts),
    .evt_in  (evt_sts),
    .armed   (armed),
    .set_req (set_req)
  );

  irq_flag_bank #(.NFLAG(NFLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (set_req),
    .clr_req (clr_req),
    .flags   (flags)
  );

  irq_cfg_regs #(.NFLAG(NFLAG)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .flags   (flags),
    .en      (en),
    .ctrl    (ctrl),
    .clr_req (clr_req),
    .rdata   (reg_rdata)
  );

  irq_pin_shaper #(.NFLAG(NFLAG)) u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .flags    (flags),
    .en       (en),
    .ctrl     (ctrl),
    .asserted (asserted),
    .drv      (irq_drv),
    .oe       (irq_oe)
  );

  for (genvar i = 0; i < NLOCK; i++) begin : g_chk
    AST_LOCK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $rose(lock_sts[i])) |=> flags[i]); // R1
    AST_UNLOCK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $fell(lock_sts[i])) |=> flags[NLOCK + i]); // R2
  end

  AST_EVT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(evt_sts[0])) |=> flags[2 * NLOCK]); // R3

  AST_OE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_oe && ctrl.open_drain) |-> asserted); // R9

endmodule

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;

  localparam int NLOCK = 5;
  localparam int NRISE = 13;
  localparam int NFLAG = 2 * NLOCK + NRISE;
  localparam logic [NFLAG-1:0] ALL1 = '1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NLOCK-1:0] lock_sts = '0;
  logic [NRISE-1:0] evt_sts = '0;
  logic             reg_wr = 1'b0;
  logic [1:0]       reg_addr = 2'd0;
  logic [NFLAG-1:0] reg_wdata = '0;
  logic [NFLAG-1:0] reg_rdata;
  logic             irq_drv;
  logic             irq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_aggregator #(.NLOCK(NLOCK), .NRISE(NRISE)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_sts  (lock_sts),
    .evt_sts   (evt_sts),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_drv   (irq_drv),
    .irq_oe    (irq_oe)
  );

  task automatic chk(input string req, input logic [NFLAG-1:0] act, input logic [NFLAG-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [NFLAG-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [NFLAG-1:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  function automatic logic [NFLAG-1:0] bitv(input int n);
    return NFLAG'(1) << n;
  endfunction

  task automatic t_reset();
    logic [NFLAG-1:0] v;
    lock_sts = '1; evt_sts = '1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    rd(2'd0, v); chk("R12 no flags from inputs high at reset", v, '0);
    rd(2'd1, v); chk("R11 enables reset", v, '0);
    rd(2'd2, v); chk("R11 control reset", v, '0);
    rd(2'd3, v); chk("R11 address 3 reads zero", v, '0);
    chk("R11 oe released", NFLAG'(irq_oe), '0);
    lock_sts = '0; evt_sts = '0;
    tick();
    rd(2'd0, v); chk("R2 all unlock flags", v, NFLAG'(((1 << NLOCK) - 1) << NLOCK));
    wr(2'd0, ALL1);
    rd(2'd0, v); chk("R4 clear all", v, '0);
  endtask

  task automatic t_lock();
    logic [NFLAG-1:0] v;
    lock_sts[2] = 1'b1; tick();
    rd(2'd0, v); chk("R1 lock rise", v, bitv(2));
    lock_sts[2] = 1'b0; tick();
    rd(2'd0, v); chk("R2 lock fall separate flag", v, bitv(2) | bitv(NLOCK + 2));
    wr(2'd0, bitv(2));
    rd(2'd0, v); chk("R4 partial clear", v, bitv(NLOCK + 2));
    wr(2'd0, '0);
    rd(2'd0, v); chk("R4 write zero keeps", v, bitv(NLOCK + 2));
    repeat (3) tick();
    rd(2'd0, v); chk("R4 sticky hold", v, bitv(NLOCK + 2));
    wr(2'd0, ALL1);
  endtask

  task automatic t_event();
    logic [NFLAG-1:0] v;
    evt_sts[7] = 1'b1; tick();
    rd(2'd0, v); chk("R3 event rise", v, bitv(2 * NLOCK + 7));
    wr(2'd0, ALL1);
    tick();
    rd(2'd0, v); chk("R3 held level sets nothing", v, '0);
    evt_sts[7] = 1'b0; tick();
    rd(2'd0, v); chk("R3 event fall sets nothing", v, '0);
    evt_sts[NRISE-1] = 1'b1; tick();
    evt_sts[NRISE-1] = 1'b0;
    rd(2'd0, v); chk("R3 top event bit", v, bitv(NFLAG - 1));
    wr(2'd0, ALL1);
  endtask

  task automatic t_set_wins();
    logic [NFLAG-1:0] v;
    lock_sts[0] = 1'b1; tick();
    lock_sts[0] = 1'b0; tick();
    wr(2'd0, ALL1);
    rd(2'd0, v); chk("R4 cleared before race", v, '0);
    lock_sts[0] = 1'b0; tick();
    lock_sts[0] = 1'b1;
    wr(2'd0, bitv(0) | bitv(NLOCK));
    rd(2'd0, v); chk("R5 set beats clear", v, bitv(0));
    lock_sts[0] = 1'b0; tick();
    wr(2'd0, ALL1);
  endtask

  task automatic t_mask();
    logic [NFLAG-1:0] v;
    evt_sts[3] = 1'b1; tick(); evt_sts[3] = 1'b0;
    wr(2'd2, NFLAG'(4'b1001));
    chk("R6 disabled flag quiet drv", NFLAG'(irq_drv), '0);
    chk("R9 push-pull oe high", NFLAG'(irq_oe), NFLAG'(1));
    wr(2'd1, bitv(2 * NLOCK + 3));
    chk("R6 enabled flag drives", NFLAG'(irq_drv), NFLAG'(1));
    wr(2'd1, bitv(1));
    chk("R6 other enable quiet", NFLAG'(irq_drv), '0);
    rd(2'd0, v); chk("R6 flag visible when masked", v, bitv(2 * NLOCK + 3));
    wr(2'd1, bitv(2 * NLOCK + 3));
    wr(2'd2, NFLAG'(4'b1000));
    chk("R7 global off drv", NFLAG'(irq_drv), '0);
    rd(2'd0, v); chk("R7 flags unaffected", v, bitv(2 * NLOCK + 3));
    rd(2'd2, v); chk("R7 control readback", v, NFLAG'(4'b1000));
  endtask

  task automatic t_polarity_type();
    wr(2'd2, NFLAG'(4'b1011));
    chk("R8 active-low asserted", NFLAG'(irq_drv), '0);
    wr(2'd2, NFLAG'(4'b1111));
    chk("R9 open-drain asserted oe", NFLAG'(irq_oe), NFLAG'(1));
    chk("R8 open-drain active-low drv", NFLAG'(irq_drv), '0);
    wr(2'd2, NFLAG'(4'b0101));
    chk("R10 pin not selected oe", NFLAG'(irq_oe), '0);
    wr(2'd2, NFLAG'(4'b0001));
    chk("R10 push-pull unselected oe", NFLAG'(irq_oe), '0);
    wr(2'd2, NFLAG'(4'b1101));
    wr(2'd0, ALL1);
    chk("R9 open-drain idle released", NFLAG'(irq_oe), '0);
    wr(2'd2, NFLAG'(4'b1011));
    chk("R8 active-low idle high", NFLAG'(irq_drv), NFLAG'(1));
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_lock();
    t_event();
    t_set_wins();
    t_mask();
    t_polarity_type();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule